// File: doc/BRIEF.md
# Compare Timer Channel

A single timer channel that counts up on a selectable time base and compares the count against two software-loaded values, A and C. The time base is either the master clock divided by one of several powers of two, or a slow-clock strobe supplied from outside. A match on C can reload the count to zero, which sets the period, and can also halt the channel, which gives a one-shot. Matches on A and C set and clear a single waveform output. This yields a square wave or PWM signal with no software involvement per period.

Software drives the channel through a small synchronous register bus. It can:
- start, stop or restart the counter with one control write;
- read the live count at any time;
- collect compare and overflow events in a status word that clears when read;
- route those events to one interrupt line through a mask with separate set and clear registers.

The register map uses word addresses:

| Address | Use |
|---|---|
| 0 | control |
| 1 | mode |
| 2 | compare A |
| 3 | compare C |
| 4 | count |
| 5 | status |
| 6 | mask set |
| 7 | mask clear |

Top module: `tmr_channel`

## Requirements
- R1: Mode bits [2:0] select the time base. Values 0, 1, 2 and 3 give one count step every 2, 8, 32 and 128 master-clock cycles, taken from a prescaler that starts at reset. Value 4 gives one step per cycle in which `slow_tick` is high. Values 5 to 7 give no steps.
- R2: With mode bit 4 clear, the counter runs from 0 to full scale and then wraps to 0. A step taken at full scale sets status bit 2 (overflow).
- R3: With mode bit 4 set, a step taken while the count equals compare C loads the count with 0 instead of incrementing it.
- R4: With mode bit 3 set, a step taken while the count equals compare C stops the channel. Status bit 8 then reads 0, and the count stays frozen until a control write restarts it.
- R5: A control write (address 0) acts as follows:
  - bit 0 starts counting;
  - bit 1 stops counting;
  - bit 2 zeroes the count and starts counting;
  - bit 1 wins over bits 0 and 2, although bit 2 still zeroes the count;
  - a control write replaces any count step in the same cycle.
- R6: The `tioa` output is low after reset. A step at count == compare A drives it high when mode bit 5 is set. A step at count == compare C drives it low when mode bit 6 is set. When both happen on the same step, low wins.
- R7: Status bits 0, 1 and 2 record a C match, an A match and an overflow. Reading address 5 clears them. An event in the same cycle as the read leaves its bit set.
- R8: Writing ones to address 6 sets mask bits [2:0], and writing ones to address 7 clears them. Both addresses read back the mask. `irq` is high exactly when some status bit is set with its mask bit set. Writing 0xFF to address 7 masks every source.
- R9: Reading address 4 returns the live count and changes neither the count nor the status flags.
- R10: After reset the following are all zero: the count, the mode, both compare values, the flags, the mask, `tioa` and `irq`, and the channel is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slow_tick | input | 1 | One-cycle strobe per slow-clock period, already synchronised |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (needed for clear-on-read) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| tioa | output | 1 | Compare-driven waveform output |
| irq | output | 1 | Masked event interrupt |

## Verification
The bench builds the channel with an 8-bit counter and the default four dividers of 2, 8, 32 and 128. With that counter, full-scale wrap, the overflow flag and a complete set/clear period of the waveform each take only a few hundred steps, so they lie well inside the run. With the slow strobe under direct bench control, the bench can place a count step in the same cycle as a control write or a status read. This exercises the priority and clear-on-read corner cases at exact cycles.

// File: rtl/tmr_pkg.sv
// Shared constants and types for the compare timer channel.
// Assumes a 32-bit register bus with word addresses 0..7.
package tmr_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;
    localparam int SEL_W  = 3;
    localparam int NSRC   = 3;   // rc match, ra match, overflow

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPA  = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPC  = 3'd3;
    localparam logic [ADDR_W-1:0] A_COUNT = 3'd4;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd5;
    localparam logic [ADDR_W-1:0] A_MSET  = 3'd6;
    localparam logic [ADDR_W-1:0] A_MCLR  = 3'd7;

    localparam int STAT_RUN_BIT = 8;

    // Mode word, bit 6 down to bit 0.
    typedef struct packed {
        logic             rc_clear;  // bit 6
        logic             ra_set;    // bit 5
        logic             reload;    // bit 4
        logic             stop;      // bit 3
        logic [SEL_W-1:0] clk_sel;   // bits 2:0
    } mode_t;

    // Event vector, bit order matches the status word.
    typedef struct packed {
        logic ovf;   // bit 2
        logic ra;    // bit 1
        logic rc;    // bit 0
    } evt_t;
endpackage

// File: rtl/tmr_clk_sel.sv
// Time-base selector: a free-running prescaler gives NUM_DIV power-of-two
// step strobes; index NUM_DIV routes the external slow strobe; higher
// indices give none. Assumes slow_tick is already synchronous to clk.
module tmr_clk_sel
    import tmr_pkg::*;
#(
    parameter int NUM_DIV  = 4,
    parameter int LOG_BASE = 1,
    parameter int LOG_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             slow_tick,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int PRE_W = LOG_BASE + LOG_STEP * (NUM_DIV - 1);
    localparam int IDX_W = $clog2(NUM_DIV);

    logic [PRE_W-1:0]   pre_q;
    logic [NUM_DIV-1:0] div_tick;

    // Prescaler counts every master cycle from reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_q + 1'b1;
    end

    // One strobe per divider: prescaler low bits all ones.
    for (genvar k = 0; k < NUM_DIV; k++) begin : g_div
        localparam int LOGK = LOG_BASE + LOG_STEP * k;
        assign div_tick[k] = &pre_q[LOGK-1:0];
    end

    // Pick the selected strobe.
    always_comb begin
        if (sel < SEL_W'(NUM_DIV))       tick = div_tick[sel[IDX_W-1:0]];
        else if (sel == SEL_W'(NUM_DIV)) tick = slow_tick;
        else                             tick = 1'b0;
    end

    // R1: the fastest divider never strobes on two cycles in a row.
    assert_div_alternate_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0 && tick) |=> !(sel == '0 && tick));
    // R1: unused selections never step.
    assert_unused_sel_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sel > SEL_W'(NUM_DIV)) |-> !tick);
endmodule

// File: rtl/tmr_core.sv
// Counter, run state, compare logic and waveform output.
// Assumes control strobes are single-cycle and take precedence over a step.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ctrl_wr,
    input  logic             ctrl_en,
    input  logic             ctrl_dis,
    input  logic             ctrl_trg,
    input  mode_t            mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_c,
    output logic [CNT_W-1:0] cnt,
    output logic             running,
    output logic             tioa,
    output evt_t             ev
);
    logic step, rc_hit, ra_hit, full;

    // Step qualifier and match detection on the current count.
    always_comb begin
        step   = running && tick && !ctrl_wr;
        rc_hit = (cnt == cmp_c);
        ra_hit = (cnt == cmp_a);
        full   = &cnt;
        ev.rc  = step && rc_hit;
        ev.ra  = step && ra_hit;
        ev.ovf = step && full;
    end

    // Count and run state: control write first, else a count step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            running <= 1'b0;
        end else if (ctrl_wr) begin
            if (ctrl_trg) cnt <= '0;
            if (ctrl_dis)                 running <= 1'b0;
            else if (ctrl_en || ctrl_trg) running <= 1'b1;
        end else if (step) begin
            cnt <= (rc_hit && mode.reload) ? '0 : cnt + 1'b1;
            if (rc_hit && mode.stop) running <= 1'b0;
        end
    end

    // Waveform output: C-clear beats A-set on the same step.
    always_ff @(posedge clk) begin
        if (!rst_n)                               tioa <= 1'b0;
        else if (step && rc_hit && mode.rc_clear) tioa <= 1'b0;
        else if (step && ra_hit && mode.ra_set)   tioa <= 1'b1;
    end

    assert_reload_on_rc_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !ctrl_wr && cnt == cmp_c && mode.reload) |=> (cnt == '0));
    assert_stop_on_rc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !ctrl_wr && cnt == cmp_c && mode.stop) |=> !running);
    assert_hold_when_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !ctrl_wr) |=> $stable(cnt));
    assert_disable_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_dis) |=> !running);
    assert_trigger_zeroes_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && ctrl_trg) |=> (cnt == '0));
    assert_rc_clear_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev.rc && mode.rc_clear) |=> !tioa);
endmodule

// File: rtl/tmr_regs.sv
// Register bus decode: mode and compare storage, control strobes,
// clear-on-read event flags, interrupt mask and read multiplexer.
// Assumes bus_rd is asserted for exactly the cycle the data is taken.
module tmr_regs
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              ctrl_wr,
    output logic              ctrl_en,
    output logic              ctrl_dis,
    output logic              ctrl_trg,
    output mode_t             mode,
    output logic [CNT_W-1:0]  cmp_a,
    output logic [CNT_W-1:0]  cmp_c,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              running,
    input  evt_t              ev,
    output logic              irq
);
    logic [NSRC-1:0] flags_q;
    logic [NSRC-1:0] mask_q;
    logic            rd_clr;
    logic            unused_wbits;

    assign unused_wbits = ^bus_wdata;

    // Control strobes decoded straight from the write cycle.
    always_comb begin
        ctrl_wr  = bus_wr && (bus_addr == A_CTRL);
        ctrl_en  = bus_wdata[0];
        ctrl_dis = bus_wdata[1];
        ctrl_trg = bus_wdata[2];
        rd_clr   = bus_rd && (bus_addr == A_STAT);
    end

    // Mode and compare storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode  <= '0;
            cmp_a <= '0;
            cmp_c <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_MODE) mode  <= mode_t'(bus_wdata[$bits(mode_t)-1:0]);
            if (bus_addr == A_CMPA) cmp_a <= bus_wdata[CNT_W-1:0];
            if (bus_addr == A_CMPC) cmp_c <= bus_wdata[CNT_W-1:0];
        end
    end

    // Event flags: a read clears, a same-cycle event re-sets.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (rd_clr ? '0 : flags_q) | ev;
    end

    // Interrupt mask with write-one-to-set and write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else if (bus_wr && bus_addr == A_MSET) mask_q <= mask_q | bus_wdata[NSRC-1:0];
        else if (bus_wr && bus_addr == A_MCLR) mask_q <= mask_q & ~bus_wdata[NSRC-1:0];
    end

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_MODE:  bus_rdata = BUS_W'(mode);
            A_CMPA:  bus_rdata = BUS_W'(cmp_a);
            A_CMPC:  bus_rdata = BUS_W'(cmp_c);
            A_COUNT: bus_rdata = BUS_W'(cnt);
            A_STAT: begin
                bus_rdata[NSRC-1:0]   = flags_q;
                bus_rdata[STAT_RUN_BIT] = running;
            end
            A_MSET, A_MCLR: bus_rdata = BUS_W'(mask_q);
            default: bus_rdata = '0;
        endcase
    end

    // Interrupt line.
    assign irq = |(flags_q & mask_q);

    assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr && ev == '0) |=> (flags_q == '0));
    assert_event_sticks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev.rc |=> flags_q[0]);
    assert_mask_all_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == A_MCLR && &bus_wdata[NSRC-1:0]) |=> (mask_q == '0 && !irq));
endmodule

// File: rtl/tmr_channel.sv
// Top of the compare timer channel: time-base selector, counter core and
// register block. Assumes a single clock domain; slow_tick pre-synchronised.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int NUM_DIV  = 4,
    parameter int LOG_BASE = 1,
    parameter int LOG_STEP = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tioa,
    output logic              irq
);
    logic             tick, ctrl_wr, ctrl_en, ctrl_dis, ctrl_trg, running;
    mode_t            mode;
    logic [CNT_W-1:0] cmp_a, cmp_c, cnt;
    evt_t             ev;

    tmr_clk_sel #(.NUM_DIV(NUM_DIV), .LOG_BASE(LOG_BASE), .LOG_STEP(LOG_STEP)) i_clk (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .sel(mode.clk_sel), .tick(tick)
    );

    tmr_core #(.CNT_W(CNT_W)) i_core (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_dis(ctrl_dis), .ctrl_trg(ctrl_trg),
        .mode(mode), .cmp_a(cmp_a), .cmp_c(cmp_c),
        .cnt(cnt), .running(running), .tioa(tioa), .ev(ev)
    );

    tmr_regs #(.CNT_W(CNT_W)) i_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en), .ctrl_dis(ctrl_dis), .ctrl_trg(ctrl_trg),
        .mode(mode), .cmp_a(cmp_a), .cmp_c(cmp_c),
        .cnt(cnt), .running(running), .ev(ev), .irq(irq)
    );
endmodule

// File: tb/test_tmr_channel.sv
module test_tmr_channel;
    localparam int CNT_W = 8;
    localparam int MAXV  = (1 << CNT_W) - 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tioa, irq;

    int tests = 0;
    int fails = 0;
    bit live = 0;
    bit done = 0;

    // Reference model state.
    int m_cnt, m_ra, m_rc, m_mode, m_flags, m_mask, m_pre;
    bit m_run, m_tioa;

    tmr_channel #(.CNT_W(CNT_W)) i_tmr_channel (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tioa(tioa), .irq(irq)
    );

    always #10 clk = ~clk;

    // Behavioural model, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_ra = 0; m_rc = 0; m_mode = 0; m_flags = 0; m_mask = 0;
            m_pre = 0; m_run = 0; m_tioa = 0;
        end else begin
            int sel, dv, ev;
            bit tk, rc_hit, ra_hit;
            sel = m_mode & 7;
            if (sel < 4) begin dv = 2 << (2 * sel); tk = ((m_pre % dv) == dv - 1); end
            else if (sel == 4) tk = slow_tick;
            else tk = 0;
            m_pre++;
            ev = 0;
            if (bus_wr && bus_addr == 0) begin
                if (bus_wdata[2]) m_cnt = 0;
                if (bus_wdata[1]) m_run = 0;
                else if (bus_wdata[0] || bus_wdata[2]) m_run = 1;
            end else if (m_run && tk) begin
                rc_hit = (m_cnt == m_rc);
                ra_hit = (m_cnt == m_ra);
                if (rc_hit) ev |= 1;
                if (ra_hit) ev |= 2;
                if (m_cnt == MAXV) ev |= 4;
                if (rc_hit && m_mode[4]) m_cnt = 0; else m_cnt = (m_cnt + 1) % (MAXV + 1);
                if (rc_hit && m_mode[3]) m_run = 0;
                if (rc_hit && m_mode[6]) m_tioa = 0;
                else if (ra_hit && m_mode[5]) m_tioa = 1;
            end
            if (bus_rd && bus_addr == 5) m_flags = 0;
            m_flags |= ev;
            if (bus_wr) begin
                case (bus_addr)
                    3'd1: m_mode = int'(bus_wdata[6:0]);
                    3'd2: m_ra = int'(bus_wdata[CNT_W-1:0]);
                    3'd3: m_rc = int'(bus_wdata[CNT_W-1:0]);
                    3'd6: m_mask = m_mask | int'(bus_wdata[2:0]);
                    3'd7: m_mask = m_mask & ~int'(bus_wdata[2:0]);
                    default: ;
                endcase
            end
        end
    end

    function automatic int exp_rd(input int a);
        case (a)
            1: return m_mode;
            2: return m_ra;
            3: return m_rc;
            4: return m_cnt;
            5: return m_flags | (int'(m_run) << 8);
            6, 7: return m_mask;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    // Per-cycle comparison of the outputs, away from the rising edge.
    always @(negedge clk) begin
        if (live) begin
            check("R6 tioa", int'(tioa), int'(m_tioa));
            check("R8 irq", int'(irq), int'((m_flags & m_mask) != 0));
        end
    end

    task automatic wr(input int a, input int d, input bit tk = 0);
        @(negedge clk);
        bus_wr = 1; bus_addr = 3'(a); bus_wdata = 32'(d); slow_tick = tk;
        @(posedge clk); #1;
        bus_wr = 0; slow_tick = 0;
    endtask

    task automatic rd(input int a, input string tag, input bit tk = 0);
        @(negedge clk);
        bus_rd = 1; bus_addr = 3'(a); slow_tick = tk;
        #2 check(tag, int'(bus_rdata), exp_rd(a));
        @(posedge clk); #1;
        bus_rd = 0; slow_tick = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); slow_tick = 1;
            @(posedge clk); #1; slow_tick = 0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        live = 1;
        // R10: reset state on every address
        for (int a = 0; a < 8; a++) rd(a, "R10 reset readback");
        check("R10 tioa low", int'(tioa), 0);

        // R1/R9: slow strobe time base, live count reads do not disturb
        wr(1, 4); wr(0, 1);
        ticks(5);
        rd(4, "R1 slow count");
        idle(3);
        rd(4, "R9 count stable");
        rd(4, "R9 count reread");
        rd(5, "R9 flags untouched");

        // R2: free-run wrap and overflow flag
        wr(0, 4);
        ticks(MAXV + 5);
        rd(5, "R2 overflow flag");
        rd(4, "R2 wrapped count");

        // R8: enable all sources
        wr(6, 7);
        rd(6, "R8 mask set");

        // R3/R4/R7: one-shot to C with reload
        wr(3, 5); wr(1, 4 | 8 | 16); wr(0, 4);
        ticks(9);
        rd(4, "R3 reloaded count");
        rd(5, "R4 stopped with flag");
        rd(5, "R7 cleared by read");
        ticks(3);
        rd(4, "R4 frozen count");

        // R6: square wave, set at A=0, clear at C=128
        wr(2, 0); wr(3, 128); wr(1, 4 | 32 | 64); wr(0, 4);
        ticks(300);
        rd(4, "R6 wave count");
        // R6: A and C equal, clear wins
        wr(2, 3); wr(3, 3); wr(1, 4 | 16 | 32 | 64); wr(0, 4);
        ticks(12);
        check("R6 clear wins", int'(tioa), 0);

        // R1: divided master clocks and unused selection
        for (int s = 0; s < 4; s++) begin
            wr(1, s); wr(0, 4);
            idle(300);
            rd(4, "R1 divided count");
        end
        wr(1, 5); wr(0, 4);
        idle(50);
        rd(4, "R1 unused select");

        // R5: control priorities
        wr(1, 4); wr(0, 2);
        wr(0, 3);
        rd(5, "R5 disable beats enable");
        wr(0, 1); ticks(4);
        wr(0, 6);
        rd(4, "R5 trigger zeroes under disable");
        rd(5, "R5 still stopped");
        wr(0, 1); ticks(2);
        wr(0, 1, 1);
        rd(4, "R5 control write replaces step");

        // R7: event in the cycle of the status read
        wr(3, 0); wr(1, 4 | 16); wr(0, 4);
        rd(5, "R7 read with event", 1);
        rd(5, "R7 flag survives");

        // R8: mask all off
        ticks(2);
        wr(7, 'hff);
        rd(7, "R8 mask cleared");
        idle(2);
        check("R8 irq low", int'(irq), 0);

        live = 0;
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule